// File: doc/BRIEF.md
# Reloadable Down-Counting Interval Timer

This block holds three countdown timer channels behind a small 32-bit register bus. Two channels are 16 bits wide and one is 32 bits wide. Each channel counts down by one on a tick enable. A control bit picks one of two tick rates. A shared divider makes both tick enables from the system clock. When a running channel is at zero and a tick arrives, it underflows. In periodic mode it then reloads from its load register. In free-run mode it wraps to all-ones. Each underflow sets a level interrupt. The interrupt stays high until software writes any value to that channel's clear register.

Software stops a channel by writing zero to its control register. To rearm a channel, software writes the control register with enable low, then writes the load value, then writes the control register again with enable high. A load write also copies the value into the counter, so the next interval starts from a known point.

Top module: `intv_timer_block`

## Requirements
- R1: After reset every load, value and control register reads 0, all interrupt outputs are low and `bus_rdata` is 0.
- R2: The fast tick enable pulses once every FAST_DIV clocks and the slow tick enable pulses once every SLOW_DIV clocks. Both dividers start counting at the release of reset.
- R3: Address decoding uses `bus_addr[7:4]`: 0x0 selects channel 0, 0x2 selects channel 1 and 0x8 selects channel 2. Within a channel, `bus_addr[3:2]` selects the register: 0 is load, 1 is the current value, 2 is control and 3 is clear. A read (`bus_sel`=1, `bus_wr`=0) returns its data on `bus_rdata` one clock later. The clear register and unmapped addresses read 0. `bus_rdata` is 0 after any cycle without a read. Writes to unmapped addresses change nothing.
- R4: Control bit 7 is the enable, bit 6 selects periodic mode and bit 3 selects the fast tick. A control read returns only these three bits, at the same positions.
- R5: An enabled channel decrements once per selected tick. Bit 3 set selects the fast tick and bit 3 clear selects the slow tick. A disabled channel holds its count.
- R6: An enabled channel that sees a tick while its count is 0 underflows. The underflow raises that channel's `irq` bit on the next clock, and the bit stays high.
- R7: On underflow in periodic mode, the counter reloads from the load register.
- R8: On underflow in free-run mode (bit 6 clear), the counter wraps to all-ones for its width.
- R9: A load write stores the value and also copies it into the counter on the next clock, whether the channel is enabled or not. It takes priority over a tick in the same cycle, and that tick causes no underflow.
- R10: A write of any data to the clear register deasserts `irq`. If an underflow happens in the same cycle, the interrupt stays set.
- R11: The 16-bit channels keep only the low 16 bits of load writes and read 0 in bits 31:16. The 32-bit channel keeps all 32 bits.
- R12: The rearm sequence (control with enable low, then load, then control with enable high) starts a fresh interval from the new load value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq | output | 3 | Level interrupt per channel (bit 0 = channel at 0x00) |

## Verification
The hardest case to reach is a clear write that lands in the same clock as an underflow. Here the set must win over the clear. A channel with load 0 in periodic mode on the fast tick underflows on every fast tick. While it runs, the stimulus issues clear writes on many consecutive cycles, so several of them coincide with an underflow. A cycle-accurate model in the bench follows every register through this window and through a seeded random mix of reads, loads, control and clear writes. Directed reads confirm the reload value, the free-run wrap value and the upper-bit masking.

// File: rtl/intv_timer_pkg.sv
package intv_timer_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 8;

    // control field positions
    localparam int CTRL_EN_BIT   = 7;
    localparam int CTRL_PER_BIT  = 6;
    localparam int CTRL_FAST_BIT = 3;

    typedef enum logic [1:0] {
        REG_LOAD  = 2'd0,
        REG_VALUE = 2'd1,
        REG_CTRL  = 2'd2,
        REG_CLEAR = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic en;
        logic periodic;
        logic fast;
    } ctrl_t;

endpackage

// File: rtl/intv_tick_gen.sv
module intv_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = (st_q.cnt == CW'(DIV - 1));
        if (tick) st_d.cnt = '0;
        else      st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        if (DIV > 1) begin : g_gap
            // R2
            tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/intv_chan.sv
module intv_chan
    import intv_timer_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         wr_reg,
    input  logic [BUS_W-1:0] wdata,
    input  reg_sel_e         rd_reg,
    input  logic             tick_fast,
    input  logic             tick_slow,
    output logic [BUS_W-1:0] rd_val,
    output logic             irq
);
    typedef struct packed {
        logic [WIDTH-1:0] load;
        logic [WIDTH-1:0] cnt;
        ctrl_t            ctrl;
        logic             irq;
    } st_t;

    st_t  st_d, st_q;
    logic tick_sel;
    logic step;
    logic ld_wr;
    logic ctl_wr;
    logic clr_wr;
    logic uf;

    always_comb begin
        st_d     = st_q;
        tick_sel = st_q.ctrl.fast ? tick_fast : tick_slow;
        step     = st_q.ctrl.en && tick_sel;
        ld_wr    = wr_en && (wr_reg == REG_LOAD);
        ctl_wr   = wr_en && (wr_reg == REG_CTRL);
        clr_wr   = wr_en && (wr_reg == REG_CLEAR);
        uf       = step && !ld_wr && (st_q.cnt == '0);

        if (ld_wr) begin
            st_d.load = wdata[WIDTH-1:0];
            st_d.cnt  = wdata[WIDTH-1:0];
        end else if (step) begin
            if (uf) st_d.cnt = st_q.ctrl.periodic ? st_q.load : '1;
            else    st_d.cnt = st_q.cnt - 1'b1;
        end

        if (ctl_wr) begin
            st_d.ctrl.en       = wdata[CTRL_EN_BIT];
            st_d.ctrl.periodic = wdata[CTRL_PER_BIT];
            st_d.ctrl.fast     = wdata[CTRL_FAST_BIT];
        end

        if (clr_wr) st_d.irq = 1'b0;
        if (uf)     st_d.irq = 1'b1;

        rd_val = '0;
        unique case (rd_reg)
            REG_LOAD:  rd_val = BUS_W'(st_q.load);
            REG_VALUE: rd_val = BUS_W'(st_q.cnt);
            REG_CTRL: begin
                rd_val[CTRL_EN_BIT]   = st_q.ctrl.en;
                rd_val[CTRL_PER_BIT]  = st_q.ctrl.periodic;
                rd_val[CTRL_FAST_BIT] = st_q.ctrl.fast;
            end
            default:   rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.irq;

    generate
        if (WIDTH < BUS_W) begin : g_narrow
            logic unused_hi;
            assign unused_hi = ^wdata[BUS_W-1:WIDTH];
        end
    endgenerate

    // R9
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_wr |=> st_q.cnt == $past(wdata[WIDTH-1:0]));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl.en && !ld_wr) |=> $stable(st_q.cnt));

    // R6
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.irq) |-> $past(uf));

    // R7
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uf && st_q.ctrl.periodic) |=> st_q.cnt == $past(st_q.load));

    // R8
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uf && !st_q.ctrl.periodic) |=> &st_q.cnt);

    // R10
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !uf) |=> !st_q.irq);

endmodule

// File: rtl/intv_timer_block.sv
module intv_timer_block
    import intv_timer_pkg::*;
#(
    parameter int FAST_DIV = 4,
    parameter int SLOW_DIV = 16,
    parameter int NARROW_W = 16,
    parameter int WIDE_W   = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic [2:0]  irq
);
    localparam int NCH = 3;

    function automatic logic [3:0] base_hi(input int ch);
        case (ch)
            0:       return 4'h0;
            1:       return 4'h2;
            default: return 4'h8;
        endcase
    endfunction

    typedef struct packed {
        logic [BUS_W-1:0] rdata;
    } st_t;

    st_t              st_d, st_q;
    logic             fast_tick, slow_tick;
    logic [NCH-1:0]   hit;
    logic [BUS_W-1:0] rd_val [NCH];
    reg_sel_e         reg_sel;
    logic             rd_req;
    logic             unused_lo;

    assign reg_sel   = reg_sel_e'(bus_addr[3:2]);
    assign rd_req    = bus_sel && !bus_wr;
    assign unused_lo = ^bus_addr[1:0];

    intv_tick_gen #(.DIV(FAST_DIV)) u_fast (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (fast_tick)
    );

    intv_tick_gen #(.DIV(SLOW_DIV)) u_slow (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (slow_tick)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            localparam int CW = (c == NCH - 1) ? WIDE_W : NARROW_W;
            assign hit[c] = (bus_addr[7:4] == base_hi(c));
            intv_chan #(.WIDTH(CW)) u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (bus_sel && bus_wr && hit[c]),
                .wr_reg   (reg_sel),
                .wdata    (bus_wdata),
                .rd_reg   (reg_sel),
                .tick_fast(fast_tick),
                .tick_slow(slow_tick),
                .rd_val   (rd_val[c]),
                .irq      (irq[c])
            );
        end
    endgenerate

    always_comb begin
        st_d       = '0;
        for (int c = 0; c < NCH; c++) begin
            if (rd_req && hit[c]) st_d.rdata = st_d.rdata | rd_val[c];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;

    // R3
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && (hit == '0)) |=> bus_rdata == '0);

endmodule

// File: tb/tb_intv_timer_block.sv
module tb_intv_timer_block;

    localparam int FAST_DIV = 3;
    localparam int SLOW_DIV = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq;

    always #5 clk = ~clk;

    intv_timer_block #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq      (irq)
    );

    // reference state, reflects the design after the next clock edge
    logic [31:0] m_ld  [3];
    logic [31:0] m_cnt [3];
    logic        m_en  [3];
    logic        m_per [3];
    logic        m_fast[3];
    logic        m_irq [3];
    int          m_fc, m_sc;
    logic [31:0] m_rd;

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_tag = "R1";
    logic        pend_v = 1'b0;
    logic [31:0] pend_exp = '0;
    string       pend_tag = "R3";
    bit          done = 1'b0;

    function automatic int chan_of(input logic [7:0] a);
        case (a[7:4])
            4'h0:    return 0;
            4'h2:    return 1;
            4'h8:    return 2;
            default: return -1;
        endcase
    endfunction

    function automatic logic [31:0] mask_of(input int ch);
        return (ch == 2) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    endfunction

    function automatic logic [31:0] mread(input int ch, input logic [1:0] r);
        case (r)
            2'd0:    return m_ld[ch];
            2'd1:    return m_cnt[ch];
            2'd2:    return {24'd0, m_en[ch], m_per[ch], 2'b00, m_fast[ch], 3'b000};
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 3; c++) begin
            m_ld[c] = '0; m_cnt[c] = '0; m_en[c] = 0;
            m_per[c] = 0; m_fast[c] = 0; m_irq[c] = 0;
        end
        m_fc = 0; m_sc = 0; m_rd = '0;
    endtask

    task automatic model_step(input logic sel, input logic wr,
                              input logic [7:0] a, input logic [31:0] d);
        logic ft, st;
        int   ch;
        logic [1:0] r;
        logic [31:0] rd;
        ft = (m_fc == FAST_DIV - 1);
        st = (m_sc == SLOW_DIV - 1);
        ch = chan_of(a);
        r  = a[3:2];
        rd = '0;
        if (sel && !wr && ch >= 0) rd = mread(ch, r);
        for (int c = 0; c < 3; c++) begin
            logic [31:0] msk, ncnt;
            logic w, tk, stp, ldw, uf;
            msk  = mask_of(c);
            w    = sel && wr && (ch == c);
            tk   = m_fast[c] ? ft : st;
            stp  = m_en[c] && tk;
            ldw  = w && (r == 2'd0);
            uf   = stp && !ldw && (m_cnt[c] == 0);
            ncnt = m_cnt[c];
            if (ldw) begin
                m_ld[c] = d & msk;
                ncnt    = d & msk;
            end else if (stp) begin
                if (uf) ncnt = m_per[c] ? m_ld[c] : msk;
                else    ncnt = (m_cnt[c] - 1) & msk;
            end
            if (w && r == 2'd3) m_irq[c] = 1'b0;
            if (uf)             m_irq[c] = 1'b1;
            if (w && r == 2'd2) begin
                m_en[c] = d[7]; m_per[c] = d[6]; m_fast[c] = d[3];
            end
            m_cnt[c] = ncnt;
        end
        m_fc = ft ? 0 : m_fc + 1;
        m_sc = st ? 0 : m_sc + 1;
        m_rd = rd;
    endtask

    task automatic check_outputs();
        logic [2:0] exp_irq;
        exp_irq = {m_irq[2], m_irq[1], m_irq[0]};
        n_vec++;
        if (irq !== exp_irq || bus_rdata !== m_rd) begin
            n_bad++;
            $display("FAIL %s: irq=%b rdata=%h expected irq=%b rdata=%h",
                     cur_tag, irq, bus_rdata, exp_irq, m_rd);
        end
        if (pend_v) begin
            n_vec++;
            if (bus_rdata !== pend_exp) begin
                n_bad++;
                $display("FAIL %s: read %h expected %h", pend_tag, bus_rdata, pend_exp);
            end
            pend_v = 1'b0;
        end
    endtask

    task automatic cycle(input logic sel, input logic wr,
                         input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        check_outputs();
        bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = d;
        model_step(sel, wr, a, d);
    endtask

    task automatic idle();
        cycle(1'b0, 1'b0, 8'h00, 32'h0);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        cycle(1'b1, 1'b1, a, d);
    endtask

    task automatic bus_read(input logic [7:0] a);
        cycle(1'b1, 1'b0, a, 32'h0);
    endtask

    task automatic expect_read(input logic [7:0] a, input logic [31:0] e, input string tag);
        bus_read(a);
        pend_v = 1'b1; pend_exp = e; pend_tag = tag;
        idle();
    endtask

    task automatic wait_irq(input int b, input string tag);
        int g;
        g = 0;
        while (!irq[b] && g < 400) begin
            idle();
            g++;
        end
        n_vec++;
        if (!irq[b]) begin
            n_bad++;
            $display("FAIL %s: irq[%0d]=%b expected 1", tag, b, irq[b]);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5eed_1234);
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        model_step(1'b0, 1'b0, 8'h00, 32'h0);

        // R1 reset state
        cur_tag = "R1";
        expect_read(8'h84, 32'h0, "R1");
        expect_read(8'h28, 32'h0, "R1");
        expect_read(8'h00, 32'h0, "R1");

        // R11 width masking
        cur_tag = "R11";
        bus_write(8'h00, 32'hABCD_1234);
        expect_read(8'h00, 32'h0000_1234, "R11");
        bus_write(8'h80, 32'hABCD_1234);
        expect_read(8'h80, 32'hABCD_1234, "R11");

        // R9 load copies into counter while disabled
        cur_tag = "R9";
        expect_read(8'h04, 32'h0000_1234, "R9");

        // R4 control encoding
        cur_tag = "R4";
        bus_write(8'h28, 32'hFFFF_FFFF);
        expect_read(8'h28, 32'h0000_00C8, "R4");
        bus_write(8'h28, 32'h0);
        bus_write(8'h2C, 32'h0);

        // R3 map holes and clear register read
        cur_tag = "R3";
        expect_read(8'h40, 32'h0, "R3");
        expect_read(8'h0C, 32'h0, "R3");
        bus_write(8'h50, 32'hFFFF_FFFF);
        expect_read(8'h88, 32'h0, "R3");

        // R7 periodic reload
        cur_tag = "R7";
        bus_write(8'h08, 32'h40);
        bus_write(8'h00, 32'd5);
        bus_write(8'h08, 32'hC8);
        wait_irq(0, "R7");
        bus_write(8'h08, 32'h0);
        expect_read(8'h04, 32'd5, "R7");

        // R10 clear with any data
        cur_tag = "R10";
        bus_write(8'h0C, 32'hDEAD_BEEF);
        idle();
        n_vec++;
        if (irq[0] !== 1'b0) begin
            n_bad++;
            $display("FAIL R10: irq[0]=%b expected 0", irq[0]);
        end

        // R8 free-run wrap
        cur_tag = "R8";
        bus_write(8'h00, 32'h0);
        bus_write(8'h08, 32'h88);
        wait_irq(0, "R8");
        bus_write(8'h08, 32'h0);
        expect_read(8'h04, 32'h0000_FFFF, "R8");
        bus_write(8'h0C, 32'h0);

        // R5 slow tick counting
        cur_tag = "R5";
        bus_write(8'h00, 32'd3);
        bus_write(8'h08, 32'h80);
        repeat (40) idle();
        bus_write(8'h08, 32'h0);

        // R2 divider rates seen through periodic intervals
        cur_tag = "R2";
        bus_write(8'h20, 32'd2);
        bus_write(8'h28, 32'hC0);
        repeat (40) idle();
        bus_write(8'h28, 32'hC8);
        repeat (30) idle();
        bus_write(8'h28, 32'h0);

        // R12 rearm sequence
        cur_tag = "R12";
        bus_write(8'h88, 32'h40);
        bus_write(8'h80, 32'd2);
        bus_write(8'h88, 32'hC8);
        repeat (30) idle();

        // R9 load while enabled
        cur_tag = "R9";
        bus_write(8'h80, 32'd7);
        expect_read(8'h84, 32'd7, "R9");

        // R10 clear colliding with underflow
        cur_tag = "R10";
        bus_write(8'h20, 32'h0);
        bus_write(8'h28, 32'hC8);
        for (int i = 0; i < 15; i++) bus_write(8'h2C, 32'(i));
        repeat (4) idle();

        // R6 random mix
        cur_tag = "R6";
        for (int i = 0; i < 3000; i++) begin
            int op, ch;
            logic [7:0] base, a;
            logic [31:0] d;
            op = $urandom % 8;
            ch = $urandom % 3;
            base = (ch == 0) ? 8'h00 : (ch == 1) ? 8'h20 : 8'h80;
            if (op == 7) base = ($urandom % 2) ? 8'h40 : 8'h60;
            a = base | 8'(($urandom % 4) << 2);
            case (op)
                0, 1, 2, 3: bus_read(a);
                4: begin
                    d = ($urandom % 4 == 0) ? $urandom : ($urandom % 12);
                    bus_write(base, d);
                end
                5: begin
                    d = $urandom;
                    if ($urandom % 4 != 0) d[7] = 1'b1;
                    bus_write(base | 8'h08, d);
                end
                6: bus_write(base | 8'h0C, $urandom);
                default: begin
                    if ($urandom % 2) bus_write(a, $urandom);
                    else              bus_read(a);
                end
            endcase
        end
        idle();
        idle();

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule